// File: doc/BRIEF.md
# Supply Monitor Flag and Reset Controller

This block is the digital side of a supply-voltage monitor. Analog comparators outside the block compare the supply against a bank of detect thresholds and a bank of warning thresholds. Each comparator output arrives here as one bit, where 1 means the supply is below that threshold. Configuration fields choose one detect level and one warning level. The block keeps a sticky flag for each channel, and software clears a flag by writing one to it. A clear takes effect only after the low condition has gone away.

Each flag can drive a level interrupt. The detect channel can instead run in reset mode. In reset mode it asserts a system reset request that stays high for as long as the selected detect comparator reports a low supply. A reset-source bit records that a power-on reset or a low-voltage reset has happened.

Software reaches the block through a small register port. Writes take effect at the clock edge, and read data is registered. The block uses two registers:
- Register 0 is control. Bit 0 is reset-enable, bit 1 is the detect interrupt enable and bit 2 is the warning interrupt enable. Bits 5:4 hold the detect level select and bits 7:6 hold the warning level select.
- Register 1 is status. Bit 0 is the detect flag, bit 1 is the warning flag and bit 2 is the reset source. Writing a one to one of these bits requests a clear of that bit.

Top module: `vmon_ctrl`

## Requirements
- R1: Each comparator input passes through two synchronizing flops. A change on the raw input reaches the flag registers at the third rising edge after it is applied.
- R2: The detect flag (status bit 0) is set whenever the synchronized comparator chosen by the detect select field (control bits 5:4) reports low. Code n selects comparator input bit n.
- R3: Writing one to status bit 0 (or bit 1) clears that flag only if its selected synchronized comparator is not low in that cycle. If the low condition and the clear fall in the same cycle, the flag stays set.
- R4: The warning flag (status bit 1) follows the rules of R2 and R3, using the warning select field (control bits 7:6). Code 0 selects the lowest warning threshold (input bit 0) and code 3 selects the highest.
- R5: With reset-enable (control bit 0) set, a low detect condition raises `sys_rst_req` at the next edge. Once raised, the request stays high while the detect condition stays low, even if reset-enable is cleared. It drops at the edge after the condition ends.
- R6: The reset-source bit (status bit 2) is set by power-on reset and in every cycle in which the reset request is being asserted. Writing one to status bit 2 clears it, unless the bit is being set in that same cycle.
- R7: `det_irq` is a registered level equal to the next detect flag AND the detect interrupt enable (control bit 1) AND NOT reset-enable. Enable changes appear one cycle after they are written.
- R8: `warn_irq` is a registered level equal to the next warning flag AND the warning interrupt enable (control bit 2). It drops in the cycle after a successful clear.
- R9: Power-on reset clears both flags, both interrupts, the reset request and the read data. It sets the control register to 0x01 (reset-enable on, interrupts off, lowest levels) and sets the reset-source bit.
- R10: `rdata` returns, one cycle after `addr` is presented, the register at that address as it stood before that edge. Addresses 2 and 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por | input | 1 | Synchronous active-high power-on reset |
| det_cmp_low | input | DET_LVLS | Raw detect comparator outputs, 1 = supply below that level |
| warn_cmp_low | input | WARN_LVLS | Raw warning comparator outputs, 1 = supply below that level |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Registered read data |
| det_irq | output | 1 | Detect interrupt request (level) |
| warn_irq | output | 1 | Warning interrupt request (level) |
| sys_rst_req | output | 1 | Low-voltage system reset request |

## Verification
The hardest case to reach is a clear write that arrives just as the synchronized comparator leaves the low state. This is also where the rule that a pending low condition overrides the clear is decided. A comparator change takes three edges to reach the flag logic, so the stimulus pulses the comparator for one cycle and then sweeps the clear write across a range of offsets from that pulse. At least one offset lands exactly on the edge where the synchronized value changes. Reset mode is checked the same way, with reset-enable cleared and the reset-source bit cleared while the supply is still low. A long randomized phase then mixes level selects, enables, clears and rare power-on resets against the bench's cycle model.

// File: rtl/vmon_pkg.sv
package vmon_pkg;
  // register addresses
  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_STAT = 1;

  // control register bit positions
  localparam int unsigned CTL_RST_EN  = 0;
  localparam int unsigned CTL_DET_IE  = 1;
  localparam int unsigned CTL_WARN_IE = 2;
  localparam int unsigned CTL_SEL_LSB = 4;

  // status register bit positions
  localparam int unsigned ST_DET  = 0;
  localparam int unsigned ST_WARN = 1;
  localparam int unsigned ST_SRC  = 2;

  // channel indices
  localparam int unsigned CH_DET  = 0;
  localparam int unsigned CH_WARN = 1;
  localparam int unsigned NUM_CH  = 2;
endpackage

// File: rtl/vmon_sync.sv
module vmon_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0] chain [W];

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) chain[b] <= '0;
      else     chain[b] <= {chain[b][STAGES-2:0], d[b]};
    end
    assign q[b] = chain[b][STAGES-1];
  end
endmodule

// File: rtl/vmon_flag.sv
module vmon_flag (
  input  logic clk,
  input  logic rst,
  input  logic low,
  input  logic ack,
  output logic flag_d,
  output logic flag_q
);
  // a pending low condition overrides the acknowledge
  always_comb flag_d = low | (flag_q & ~ack);

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_d;
  end

  p_low_sets_r2: assert property (@(posedge clk) disable iff (rst) low |=> flag_q);
  p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (flag_q && ack && !low) |=> !flag_q);
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !ack) |=> flag_q);
endmodule

// File: rtl/vmon_regs.sv
module vmon_regs
  import vmon_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DSEL_W = 2,
  parameter int unsigned WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] flags,
  input  logic              src_set,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_en,
  output logic              det_ie,
  output logic              warn_ie,
  output logic [DSEL_W-1:0] det_sel,
  output logic [WSEL_W-1:0] warn_sel,
  output logic [NUM_CH-1:0] ack,
  output logic              rst_src
);
  localparam int unsigned WSEL_LSB = CTL_SEL_LSB + DSEL_W;

  logic              wr_ctrl, wr_stat, src_clr;
  logic [DATA_W-1:0] ctrl_view, stat_view;

  always_comb begin
    wr_ctrl = wr_en && (addr == ADDR_W'(REG_CTRL));
    wr_stat = wr_en && (addr == ADDR_W'(REG_STAT));
    ack[CH_DET]  = wr_stat & wdata[ST_DET];
    ack[CH_WARN] = wr_stat & wdata[ST_WARN];
    src_clr      = wr_stat & wdata[ST_SRC];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_en   <= 1'b1;
      det_ie   <= 1'b0;
      warn_ie  <= 1'b0;
      det_sel  <= '0;
      warn_sel <= '0;
    end else if (wr_ctrl) begin
      rst_en   <= wdata[CTL_RST_EN];
      det_ie   <= wdata[CTL_DET_IE];
      warn_ie  <= wdata[CTL_WARN_IE];
      det_sel  <= wdata[CTL_SEL_LSB +: DSEL_W];
      warn_sel <= wdata[WSEL_LSB +: WSEL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rst_src <= 1'b1;
    else if (src_set) rst_src <= 1'b1;
    else if (src_clr) rst_src <= 1'b0;
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTL_RST_EN]             = rst_en;
    ctrl_view[CTL_DET_IE]             = det_ie;
    ctrl_view[CTL_WARN_IE]            = warn_ie;
    ctrl_view[CTL_SEL_LSB +: DSEL_W]  = det_sel;
    ctrl_view[WSEL_LSB +: WSEL_W]     = warn_sel;
    stat_view = '0;
    stat_view[ST_DET]  = flags[CH_DET];
    stat_view[ST_WARN] = flags[CH_WARN];
    stat_view[ST_SRC]  = rst_src;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      unique case (addr)
        ADDR_W'(REG_CTRL): rdata <= ctrl_view;
        ADDR_W'(REG_STAT): rdata <= stat_view;
        default:           rdata <= '0;
      endcase
    end
  end

  p_src_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (src_clr && !src_set) |=> !rst_src);
  p_src_set_r6: assert property (@(posedge clk) disable iff (rst) src_set |=> rst_src);
  p_ctrl_stable_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> $stable(det_sel) && $stable(warn_sel) && $stable(rst_en));
endmodule

// File: rtl/vmon_ctrl.sv
module vmon_ctrl
  import vmon_pkg::*;
#(
  parameter int unsigned DET_LVLS  = 4,
  parameter int unsigned WARN_LVLS = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 2
) (
  input  logic                 clk,
  input  logic                 por,
  input  logic [DET_LVLS-1:0]  det_cmp_low,
  input  logic [WARN_LVLS-1:0] warn_cmp_low,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic                 det_irq,
  output logic                 warn_irq,
  output logic                 sys_rst_req
);
  localparam int unsigned DSEL_W = (DET_LVLS  > 1) ? $clog2(DET_LVLS)  : 1;
  localparam int unsigned WSEL_W = (WARN_LVLS > 1) ? $clog2(WARN_LVLS) : 1;
  localparam int unsigned CMP_W  = DET_LVLS + WARN_LVLS;

  logic [CMP_W-1:0]     cmp_s;
  logic [DET_LVLS-1:0]  det_s;
  logic [WARN_LVLS-1:0] warn_s;
  logic [NUM_CH-1:0]    low, ack, flag_d, flag_q;
  logic                 rst_en, det_ie, warn_ie, rst_src, rst_req_d;
  logic [DSEL_W-1:0]    det_sel;
  logic [WSEL_W-1:0]    warn_sel;

  vmon_sync #(.W(CMP_W), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (por),
    .d   ({warn_cmp_low, det_cmp_low}),
    .q   (cmp_s)
  );

  always_comb begin
    det_s        = cmp_s[DET_LVLS-1:0];
    warn_s       = cmp_s[DET_LVLS +: WARN_LVLS];
    low[CH_DET]  = det_s[det_sel];
    low[CH_WARN] = warn_s[warn_sel];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    vmon_flag u_flag (
      .clk    (clk),
      .rst    (por),
      .low    (low[c]),
      .ack    (ack[c]),
      .flag_d (flag_d[c]),
      .flag_q (flag_q[c])
    );
  end

  // once raised, the request holds while the detect condition persists
  always_comb rst_req_d = low[CH_DET] & (rst_en | sys_rst_req);

  always_ff @(posedge clk) begin
    if (por) begin
      sys_rst_req <= 1'b0;
      det_irq     <= 1'b0;
      warn_irq    <= 1'b0;
    end else begin
      sys_rst_req <= rst_req_d;
      det_irq     <= flag_d[CH_DET] & det_ie & ~rst_en;
      warn_irq    <= flag_d[CH_WARN] & warn_ie;
    end
  end

  vmon_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .DSEL_W (DSEL_W),
    .WSEL_W (WSEL_W)
  ) u_regs (
    .clk      (clk),
    .rst      (por),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .flags    (flag_q),
    .src_set  (rst_req_d),
    .rdata    (rdata),
    .rst_en   (rst_en),
    .det_ie   (det_ie),
    .warn_ie  (warn_ie),
    .det_sel  (det_sel),
    .warn_sel (warn_sel),
    .ack      (ack),
    .rst_src  (rst_src)
  );

  p_rst_hold_r5: assert property (@(posedge clk) disable iff (por)
    (sys_rst_req && low[CH_DET]) |=> sys_rst_req);
  p_rst_release_r5: assert property (@(posedge clk) disable iff (por)
    !low[CH_DET] |=> !sys_rst_req);
  p_rst_src_r6: assert property (@(posedge clk) disable iff (por) sys_rst_req |-> rst_src);
  p_det_irq_flag_r7: assert property (@(posedge clk) disable iff (por) det_irq |-> flag_q[CH_DET]);
  p_det_irq_mode_r7: assert property (@(posedge clk) disable iff (por)
    $rose(det_irq) |-> $past(!rst_en));
  p_warn_irq_flag_r8: assert property (@(posedge clk) disable iff (por)
    warn_irq |-> flag_q[CH_WARN]);
endmodule

// File: tb/vmon_ctrl_bench.sv
module vmon_ctrl_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       por;
  logic [3:0] det_cmp_low, warn_cmp_low;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       det_irq, warn_irq, sys_rst_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model state
  int m_re, m_die, m_wie, m_dsel, m_wsel;
  int m_det, m_warn, m_rq, m_src, m_dirq, m_wirq, m_rdata, m_raddr;
  int qd[$], qw[$];

  always #(CLK_P/2) clk = ~clk;

  vmon_ctrl u_vmon_ctrl (
    .clk(clk), .por(por), .det_cmp_low(det_cmp_low), .warn_cmp_low(warn_cmp_low),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .det_irq(det_irq), .warn_irq(warn_irq), .sys_rst_req(sys_rst_req)
  );

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R7 det_irq", int'(det_irq), m_dirq);
    chk("R8 warn_irq", int'(warn_irq), m_wirq);
    chk("R5 sys_rst_req", int'(sys_rst_req), m_rq);
    if (m_raddr == 9)      chk("R9 rdata after power-on", int'(rdata), m_rdata);
    else if (m_raddr == 0) chk("R9 R10 R4 control readback", int'(rdata), m_rdata);
    else if (m_raddr == 1) begin
      chk("R1 R2 R3 detect flag", int'(rdata[0]), m_rdata & 1);
      chk("R4 R3 warning flag", int'(rdata[1]), (m_rdata >> 1) & 1);
      chk("R6 reset source", int'(rdata[2]), (m_rdata >> 2) & 1);
      chk("R10 status unused bits", int'(rdata[7:3]), m_rdata >> 3);
    end else chk("R10 unmapped address", int'(rdata), m_rdata);
  endtask

  // one clock of the behavioural model, inputs held over the coming edge
  task automatic step(int p, int dc, int wc, int w, int a, int wd);
    int ld, lw, dack, wack, sclr, ndet, nwarn, nrq;
    if (p != 0) begin
      m_re = 1; m_die = 0; m_wie = 0; m_dsel = 0; m_wsel = 0;
      m_det = 0; m_warn = 0; m_rq = 0; m_src = 1; m_dirq = 0; m_wirq = 0;
      m_rdata = 0; m_raddr = 9;
      qd = {0, 0}; qw = {0, 0};
      return;
    end
    ld = (qd[0] >> m_dsel) & 1;
    lw = (qw[0] >> m_wsel) & 1;
    dack = (w != 0 && a == 1) ? (wd & 1) : 0;
    wack = (w != 0 && a == 1) ? ((wd >> 1) & 1) : 0;
    sclr = (w != 0 && a == 1) ? ((wd >> 2) & 1) : 0;
    ndet  = ld | (m_det & (dack ^ 1));
    nwarn = lw | (m_warn & (wack ^ 1));
    nrq   = ld & (m_re | m_rq);
    if (a == 0) m_rdata = m_re | (m_die << 1) | (m_wie << 2) | (m_dsel << 4) | (m_wsel << 6);
    else if (a == 1) m_rdata = m_det | (m_warn << 1) | (m_src << 2);
    else m_rdata = 0;
    m_raddr = a;
    m_dirq = ndet & m_die & (m_re ^ 1);
    m_wirq = nwarn & m_wie;
    m_src  = nrq | (m_src & (sclr ^ 1));
    m_det = ndet; m_warn = nwarn; m_rq = nrq;
    if (w != 0 && a == 0) begin
      m_re = wd & 1; m_die = (wd >> 1) & 1; m_wie = (wd >> 2) & 1;
      m_dsel = (wd >> 4) & 3; m_wsel = (wd >> 6) & 3;
    end
    qd.push_back(dc); void'(qd.pop_front());
    qw.push_back(wc); void'(qw.pop_front());
  endtask

  task automatic tick(int p, int dc, int wc, int w, int a, int wd);
    @(negedge clk);
    compare_all();
    por = p[0]; det_cmp_low = dc[3:0]; warn_cmp_low = wc[3:0];
    wr_en = w[0]; addr = a[1:0]; wdata = wd[7:0];
    step(p, dc, wc, w, a, wd);
  endtask

  task automatic idle(int n, int dc, int wc, int a);
    for (int i = 0; i < n; i++) tick(0, dc, wc, 0, a, 0);
  endtask

  initial begin
    por = 1; det_cmp_low = 0; warn_cmp_low = 0; wr_en = 0; addr = 0; wdata = 0;
    step(1, 0, 0, 0, 0, 0);
    tick(1, 0, 0, 0, 0, 0);
    idle(3, 0, 0, 0);                       // R9 defaults read 0x01
    idle(2, 0, 0, 1);                       // R6 source set by power-on
    // interrupt mode: detect level 1, warning level 2
    tick(0, 0, 0, 1, 0, 8'h96);
    idle(5, 4'b0010, 0, 1);                 // R1 R2 flag after sync delay
    tick(0, 4'b0010, 0, 1, 1, 1);           // R3 clear while low is refused
    idle(1, 0, 0, 1);
    tick(0, 0, 0, 1, 1, 1);                 // R3 synced value still low
    idle(4, 0, 0, 1);
    tick(0, 0, 0, 1, 1, 1);                 // R3 clear accepted, R7 irq drops
    idle(2, 0, 0, 1);
    // sweep clear offset around the synced edge (R1 R3)
    for (int off = 0; off < 6; off++) begin
      tick(0, 4'b0010, 4'b0100, 0, 1, 0);
      idle(off, 0, 0, 1);
      tick(0, 0, 0, 1, 1, 3);
      idle(5, 0, 0, 1);
      tick(0, 0, 0, 1, 1, 3);
      idle(2, 0, 0, 1);
    end
    // warning level selection sweep (R4 R8)
    for (int lv = 0; lv < 4; lv++) begin
      tick(0, 0, 0, 1, 0, (lv << 6) | 8'h04);
      for (int b = 0; b < 4; b++) begin
        tick(0, 0, 1 << b, 0, 1, 0);
        idle(4, 0, 0, 1);
        tick(0, 0, 0, 1, 1, 2);
        idle(2, 0, 0, 1);
      end
    end
    // reset mode with detect irq enabled (R5 R6 R7)
    tick(0, 0, 0, 1, 0, 8'h13);
    idle(4, 4'b0010, 0, 1);
    tick(0, 4'b0010, 0, 1, 0, 8'h12);       // R5 clearing enable keeps the request
    tick(0, 4'b0010, 0, 1, 1, 4);           // R6 clear refused while held
    idle(3, 4'b0010, 0, 1);
    idle(4, 0, 0, 1);
    tick(0, 0, 0, 1, 1, 7);                 // R6 clear accepted
    idle(3, 0, 0, 1);
    idle(3, 0, 0, 2);                       // R10 unmapped read
    // randomized phase
    for (int i = 0; i < 4000; i++) begin
      int r, w, a, wd, p;
      r  = $urandom_range(0, 99);
      p  = ($urandom_range(0, 599) == 0) ? 1 : 0;
      w  = (r < 20) ? 1 : 0;
      a  = $urandom_range(0, 3);
      wd = $urandom_range(0, 255);
      tick(p, ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : 0,
              ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : 0, w, a, wd);
    end
    idle(2, 0, 0, 1);
    @(negedge clk);
    compare_all();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule